// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter assembled from identical narrow slices. Each slice holds a few bits of count state. Every bit changes together on the rising clock edge. A slice can take a parallel value from a data bus, and an active-low clear empties it at once, without waiting for a clock edge. Each slice has two count enables. The first is a global step enable. The second is a trickle enable that also gates the slice's terminal-count flag. The terminal-count flag of one slice feeds the trickle enable of the slice above it, so the chain behaves as one wide counter.

The wrapper sets the number of slices and the slice width with parameters. All slices share the global step enable, the load control and the clear. The lowest slice takes its trickle enable from a top-level input. The flag from the highest slice is brought out as the chain's terminal count.

Inside each slice, a decoder picks one of three clocked operations on every edge:
- HOLD keeps the count.
- LOAD copies the data bus into the count.
- STEP adds one to the count.

The asynchronous CLEAR path overrides all three. LOAD is chosen whenever the load control is low. Otherwise STEP is chosen if both enables are high, and HOLD is chosen if either enable is low.

Top module: `cnt_chain`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros. The clear takes effect without a clock edge and overrides load and enables.
- R2: With `clr_n` high and `load_n` low, the rising edge copies `din` into `q`.
- R3: A load happens whatever the levels of `cnt_en` and `trk_en`. A load with both enables high gives exactly `din`, not `din`+1.
- R4: With `load_n` high, `q` holds its value on an edge unless both `cnt_en` and `trk_en` are high.
- R5: With `load_n` high, both enables high and `q` at all ones, the next edge wraps `q` to zero.
- R6: `tc_out` is 1 exactly when `trk_en` is 1 and every bit of `q` is 1. It follows its inputs with no register stage.
- R7: Slice k (k>0) steps only when every lower slice is at all ones. Chained slices therefore carry like a single `SLICE_W*N_SLICES`-bit counter (e.g. 0x00F steps to 0x010, and 0x0FF steps to 0x100).
- R8: After a load of all ones with `trk_en` high, `tc_out` is 1 immediately after that load edge.
- R9: The first rising edge after `clr_n` returns high acts normally. With both enables high, zero steps to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Parallel load request, active low |
| cnt_en | input | 1 | Global step enable, shared by all slices |
| trk_en | input | 1 | Trickle enable into the lowest slice |
| din | input | SLICE_W*N_SLICES | Parallel load value |
| q | output | SLICE_W*N_SLICES | Current count |
| tc_out | output | 1 | Terminal count of the whole chain |

## Verification
The hardest cases to reach are carries across slice boundaries and the chain-wide terminal count. Counting up from zero to those values would take thousands of edges. The bench therefore uses the load path to place the count just below each boundary, then steps once. It loads 0x00F and 0x0FF to exercise the ripple of the trickle enable through the slices. It loads all ones to exercise wrap-around and to check `tc_out` right after the load edge, with the trickle enable both high and low.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    // Clocked operation chosen for a slice on each rising edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output cnt_op_e op
);
    // Load has priority over both enables; a step needs both enables.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_trk) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_par,
    input  logic         en_trk,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_op_e      op;
    logic [W-1:0] q_r;

    cnt_op_decode u_dec (
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    // State register: asynchronous clear, then the decoded operation.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q_r <= '0;
        end else begin
            unique case (op)
                OP_LOAD: q_r <= din;
                OP_STEP: q_r <= q_r + ONE;
                OP_HOLD: q_r <= q_r;
                default: q_r <= q_r;
            endcase
        end
    end

    // Outputs: the count and the trickle-gated terminal count, no register.
    always_comb begin
        q  = q_r;
        tc = en_trk && (&q_r);
    end
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int SLICE_W  = 4,
    parameter int N_SLICES = 3
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          load_n,
    input  logic                          cnt_en,
    input  logic                          trk_en,
    input  logic [SLICE_W*N_SLICES-1:0]   din,
    output logic [SLICE_W*N_SLICES-1:0]   q,
    output logic                          tc_out
);
    localparam int TOTAL_W = SLICE_W * N_SLICES;

    // trk[k] is the trickle enable into slice k; trk[k+1] is its terminal count.
    logic [N_SLICES:0] trk;

    assign trk[0] = trk_en;

    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        cnt_slice #(.W(SLICE_W)) u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_par (cnt_en),
            .en_trk (trk[k]),
            .din    (din[k*SLICE_W +: SLICE_W]),
            .q      (q[k*SLICE_W +: SLICE_W]),
            .tc     (trk[k+1])
        );
    end

    assign tc_out = trk[N_SLICES];

    if (TOTAL_W < 1) begin : g_bad_width
        initial $error("cnt_chain: total width must be positive");
    end
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int TOTAL_W = 12
) (
    input logic               clk,
    input logic               clr_n,
    input logic               load_n,
    input logic               cnt_en,
    input logic               trk_en,
    input logic [TOTAL_W-1:0] din,
    input logic [TOTAL_W-1:0] q,
    input logic               tc_out
);
    // R1: clear seen at an edge leaves zero at the next edge
    p_clear_zero_r1: assert property (@(posedge clk)
        !clr_n |=> q == '0);

    // R2, R3: load copies the bus whatever the enables
    p_load_copies_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));

    // R4: without both enables the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && trk_en)) |=> $stable(q));

    // R5: all ones wraps to zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && trk_en && (&q)) |=> q == '0);

    // R7: chained slices step as one wide counter
    p_wide_step_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && trk_en) |=> q == TOTAL_W'($past(q) + 1'b1));

    // R6: chain terminal count agrees with the whole count and trickle input
    p_tc_r6: assert property (@(posedge clk) disable iff (!clr_n)
        tc_out == (trk_en && (&q)));
endmodule

bind cnt_chain cnt_chain_chk #(.TOTAL_W(SLICE_W*N_SLICES)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .cnt_en (cnt_en),
    .trk_en (trk_en),
    .din    (din),
    .q      (q),
    .tc_out (tc_out)
);

// File: tb/tb_cnt_chain.sv
`timescale 1ns/1ps
module tb_cnt_chain;
    localparam int SW = 4;
    localparam int NS = 3;
    localparam int TW = SW * NS;
    localparam logic [TW-1:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          clr_n = 1'b0;
    logic          load_n = 1'b1;
    logic          cnt_en = 1'b0;
    logic          trk_en = 1'b0;
    logic [TW-1:0] din = '0;
    logic [TW-1:0] q;
    logic          tc_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cnt_chain #(.SLICE_W(SW), .N_SLICES(NS)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .trk_en(trk_en), .din(din), .q(q), .tc_out(tc_out)
    );

    task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one rising edge, then return at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(logic [TW-1:0] v);
        load_n = 1'b0; din = v;
        tick();
        load_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset state", q, '0);
        clr_n = 1'b1;
    endtask

    task automatic t_load();
        cnt_en = 1'b0; trk_en = 1'b0;
        do_load(12'hABC);
        check("R2 load", q, 12'hABC);
        check("R4 hold after load", q, 12'hABC);
    endtask

    task automatic t_load_override();
        cnt_en = 1'b1; trk_en = 1'b1;
        do_load(12'h123);
        check("R3 load with enables high", q, 12'h123);
        cnt_en = 1'b0; trk_en = 1'b0;
    endtask

    task automatic t_hold();
        do_load(12'h005);
        cnt_en = 1'b0; trk_en = 1'b1; tick();
        check("R4 hold cnt_en low", q, 12'h005);
        cnt_en = 1'b1; trk_en = 1'b0; tick();
        check("R4 hold trk_en low", q, 12'h005);
        cnt_en = 1'b1; trk_en = 1'b1;
        repeat (3) tick();
        check("R4 step x3", q, 12'h008);
        cnt_en = 1'b0;
    endtask

    task automatic t_wrap();
        trk_en = 1'b1; do_load(MAXV);
        cnt_en = 1'b1; tick();
        check("R5 wrap to zero", q, '0);
        cnt_en = 1'b0;
    endtask

    task automatic t_carry();
        trk_en = 1'b1; do_load(12'h00E);
        cnt_en = 1'b1; tick();
        check("R7 no carry below boundary", q, 12'h00F);
        tick();
        check("R7 carry slice0 to slice1", q, 12'h010);
        cnt_en = 1'b0; do_load(12'h0FF);
        cnt_en = 1'b1; tick();
        check("R7 carry into slice2", q, 12'h100);
        cnt_en = 1'b0;
    endtask

    task automatic t_tc();
        trk_en = 1'b1; do_load(MAXV);
        check("R8 tc right after max load", TW'(tc_out), TW'(1));
        trk_en = 1'b0; #1;
        check("R6 tc gated by trk_en", TW'(tc_out), TW'(0));
        trk_en = 1'b1; do_load(12'hFFE);
        check("R6 tc low below max", TW'(tc_out), TW'(0));
        do_load(12'hF0F);
        check("R6 tc low partial ones", TW'(tc_out), TW'(0));
    endtask

    task automatic t_async_clear();
        do_load(12'h777);
        #1 clr_n = 1'b0; load_n = 1'b0; cnt_en = 1'b1; trk_en = 1'b1;
        #0.5;
        check("R1 clear without edge", q, '0);
        tick();
        check("R1 clear beats load", q, '0);
        load_n = 1'b1;
        clr_n = 1'b1;
        tick();
        check("R9 first edge after clear", q, 12'h001);
        cnt_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_load();
        t_load_override();
        t_hold();
        t_wrap();
        t_carry();
        t_tc();
        t_async_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule